// File: doc/BRIEF.md
# Satellite LNB Supply Control Register Slave (two-wire serial)

This block is the serial control front end of an LNB supply controller. It is a 7-bit-address two-wire serial slave that works at standard and fast bus rates when the system clock is at least roughly 20 times the bus bit rate. Four 8-bit system registers sit behind it. There is no separate sub-address byte. In every data byte a master writes, the upper three bits name the target register and the lower five bits are the new contents. The three writable registers drive the regulator's configuration fields. The first register holds five live fault and status flags that come in from the analog side, and writes cannot change it.

A read streams the registers out in a fixed rotation that starts at the status register each time. Every byte goes out MSB first and carries its own select code in its top three bits, so software can tell which register it is looking at. The bus lines arrive as separate level inputs. The slave pulls SDA low by raising an output-enable; the pad is not modelled. Two strap inputs set the low two address bits. While the power-good input is low, the slave keeps all registers at zero, ignores the bus and never acknowledges.

Top module: `lnb_ctl_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 00010 followed by strap[1] and strap[0]. Bit 0 selects the direction (1 = read). After a mismatch, no byte is acknowledged and no register changes until the next START.
- R2: In a write, each data byte is split into bits 7:5 (select code) and bits 4:0 (payload). Code 001 loads `tone_cfg`, code 010 loads `cmd_cfg` and code 011 loads `out_cfg`. The new value appears on the port before the acknowledge clock of that byte ends.
- R3: A written byte with code 000 (status register) or with codes 100 to 111 is acknowledged but changes no configuration output.
- R4: A read byte is {select code, payload}, sent MSB first. For the status register this is {000, status_i}, with status_i taken at the SCL falling edge that starts that byte.
- R5: Read bytes come in the order status, 001, 010, 011, then status again. Every new read address phase restarts at status.
- R6: A master NACK after a read byte ends the read. The slave leaves SDA released for any further clocks until the next START.
- R7: While pwr_ok is low, all configuration outputs are zero, no byte is acknowledged and no write takes effect. When pwr_ok returns, the outputs stay zero until they are written.
- R8: After reset, all configuration outputs are zero and SDA is released.
- R9: A STOP returns the slave to idle, and later bytes are ignored until a START. A repeated START begins a fresh address phase, even in the middle of a transaction.
- R10: A write transaction can carry any number of data bytes. Each one is acknowledged and applied in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply good; low holds registers at zero and mutes the slave |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | High pulls SDA low |
| strap | input | 2 | Low two bits of the slave address |
| status_i | input | 5 | Live fault/status flags shown in the status register |
| tone_cfg | output | 5 | Payload of register code 001 |
| cmd_cfg | output | 5 | Payload of register code 010 |
| out_cfg | output | 5 | Payload of register code 011 |

## Verification
The bench drives bytes with reserved and status select codes. A decoder that masked the code badly would let such a byte overwrite a configuration field. It reads five bytes in a row to cover the rotation wrap, and starts a second read to confirm the restart at status; a pointer that carried over between transactions would return the wrong register first. It clocks bytes after a master NACK, after a STOP and after a wrong address, where a slave that failed to go idle would pull SDA low. It drops power-good in the middle of the run to check that the registers clear, the slave goes silent and the cleared state holds after power returns. A repeated START placed straight after a write byte checks that the address phase restarts.

// File: rtl/lnb_i2c_pkg.sv
package lnb_i2c_pkg;

  localparam int BYTE_W    = 8;
  localparam int CODE_W    = 3;
  localparam int PAYLOAD_W = 5;
  localparam int REG_COUNT = 4;
  localparam int PTR_W     = $clog2(REG_COUNT);
  localparam int CNT_W     = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } xfer_state_t;

  // Seven received address bits against the fixed base plus strap pins.
  function automatic logic addr_hit(input logic [6:0] rx,
                                    input logic [4:0] base,
                                    input logic [1:0] strap);
    return rx == {base, strap};
  endfunction

  // Byte returned for a read: select code on top, payload below.
  function automatic logic [BYTE_W-1:0] pack_rd(input logic [PTR_W-1:0] ptr,
                                                input logic [PAYLOAD_W-1:0] pl);
    return {{(CODE_W-PTR_W){1'b0}}, ptr, pl};
  endfunction

  // Read rotation with wrap back to the status register.
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] ptr);
    if (ptr == PTR_W'(REG_COUNT - 1)) return '0;
    return ptr + 1'b1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_now;

  // Synchronisers reset to the idle-bus level (both lines high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_now & ~scl_prev;
  assign scl_fall = ~scl_now & scl_prev;
  assign start_ev = scl_now & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
  import lnb_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b00010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              sda_oe,
  output logic              wr_commit,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              ev_addr_hit,
  output logic              rd_done
);

  xfer_state_t       state;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [CNT_W-1:0]  cnt;
  logic              is_rd;
  logic              mack;
  logic [PTR_W-1:0]  ptr;

  logic live;
  logic byte_done;
  logic rd_load;
  logic hit;

  assign live      = pwr_ok & ~start_ev & ~stop_ev;
  assign byte_done = scl_fall & (cnt == CNT_W'(BYTE_W));
  assign hit       = addr_hit(shreg[BYTE_W-1:1], ADDR_BASE, strap);

  assign ev_addr_hit = live & (state == ST_ADDR) & byte_done & hit;
  assign wr_commit   = live & (state == ST_WR_BYTE) & byte_done;
  assign wr_byte     = shreg;
  assign rd_load     = live & scl_fall &
                       (((state == ST_ADDR_ACK) & is_rd) | ((state == ST_RD_ACK) & mack));
  assign rd_done     = live & scl_fall & (state == ST_RD_ACK) & ~mack;
  assign rd_ptr      = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      shreg <= '0;
      txreg <= '0;
      cnt   <= '0;
      is_rd <= 1'b0;
      mack  <= 1'b0;
      ptr   <= '0;
    end else if (!pwr_ok) begin
      state <= ST_IDLE;
      cnt   <= '0;
      is_rd <= 1'b0;
      mack  <= 1'b0;
    end else if (start_ev) begin
      state <= ST_ADDR;
      cnt   <= '0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
    end else if (rd_load) begin
      txreg <= rd_byte_i;
      ptr   <= next_ptr(ptr);
      cnt   <= '0;
      state <= ST_RD_BYTE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            if (hit) begin
              state <= ST_ADDR_ACK;
              is_rd <= shreg[0];
              ptr   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            state <= ST_WR_ACK;
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            state <= ST_WR_BYTE;
            cnt   <= '0;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            txreg <= {txreg[BYTE_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W - 1)) state <= ST_RD_ACK;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack <= ~sda_lvl;
          else if (scl_fall) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe = pwr_ok & ((state == ST_ADDR_ACK) | (state == ST_WR_ACK) |
                            ((state == ST_RD_BYTE) & ~txreg[BYTE_W-1]));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import lnb_i2c_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 pwr_ok,
  input  logic                                 wr_en,
  input  logic [BYTE_W-1:0]                    wr_byte,
  input  logic [PAYLOAD_W-1:0]                 status_i,
  input  logic [PTR_W-1:0]                     rd_ptr,
  output logic [BYTE_W-1:0]                    rd_byte,
  output logic [REG_COUNT-1:0]                 wr_sel,
  output logic [REG_COUNT-1:1][PAYLOAD_W-1:0]  cfg_q
);

  logic [PAYLOAD_W-1:0] rd_pl [REG_COUNT];
  logic [CODE_W-1:0]    code;

  assign code     = wr_byte[BYTE_W-1 -: CODE_W];
  assign rd_pl[0] = status_i;

  for (genvar s = 0; s < REG_COUNT; s++) begin : g_sel
    assign wr_sel[s] = wr_en & (code == CODE_W'(s));
  end

  for (genvar r = 1; r < REG_COUNT; r++) begin : g_reg
    logic [PAYLOAD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (!pwr_ok)    q <= '0;
      else if (wr_sel[r])  q <= wr_byte[PAYLOAD_W-1:0];
    end
    assign cfg_q[r] = q;
    assign rd_pl[r] = q;
  end

  assign rd_byte = pack_rd(rd_ptr, rd_pl[rd_ptr]);

endmodule

// File: rtl/lnb_ctl_i2c_slave.sv
module lnb_ctl_i2c_slave
  import lnb_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE   = 5'b00010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_ok,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [1:0]           strap,
  input  logic [PAYLOAD_W-1:0] status_i,
  output logic [PAYLOAD_W-1:0] tone_cfg,
  output logic [PAYLOAD_W-1:0] cmd_cfg,
  output logic [PAYLOAD_W-1:0] out_cfg
);

  logic                                sda_lvl;
  logic                                scl_rise;
  logic                                scl_fall;
  logic                                ev_start;
  logic                                ev_stop;
  logic                                ev_addr_hit;
  logic                                wr_commit;
  logic                                rd_done;
  logic [BYTE_W-1:0]                   wr_byte;
  logic [BYTE_W-1:0]                   rd_byte;
  logic [PTR_W-1:0]                    rd_ptr;
  logic [REG_COUNT-1:0]                wr_sel;
  logic [REG_COUNT-1:1][PAYLOAD_W-1:0] cfg_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (ev_start),
    .stop_ev  (ev_stop)
  );

  i2c_xfer_engine #(.ADDR_BASE(ADDR_BASE)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok      (pwr_ok),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_ev    (ev_start),
    .stop_ev     (ev_stop),
    .strap       (strap),
    .rd_byte_i   (rd_byte),
    .rd_ptr      (rd_ptr),
    .sda_oe      (sda_oe),
    .wr_commit   (wr_commit),
    .wr_byte     (wr_byte),
    .ev_addr_hit (ev_addr_hit),
    .rd_done     (rd_done)
  );

  sysreg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .wr_en    (wr_commit),
    .wr_byte  (wr_byte),
    .status_i (status_i),
    .rd_ptr   (rd_ptr),
    .rd_byte  (rd_byte),
    .wr_sel   (wr_sel),
    .cfg_q    (cfg_q)
  );

  assign tone_cfg = cfg_q[1];
  assign cmd_cfg  = cfg_q[2];
  assign out_cfg  = cfg_q[3];

endmodule

// File: rtl/lnb_ctl_i2c_slave_chk.sv
module lnb_ctl_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic       sda_oe,
  input logic [4:0] tone_cfg,
  input logic [4:0] cmd_cfg,
  input logic [4:0] out_cfg,
  input logic       ev_addr_hit,
  input logic       ev_stop,
  input logic       wr_commit,
  input logic       rd_done,
  input logic [7:0] wr_byte,
  input logic [3:0] wr_sel
);

  logic [14:0] fields;
  assign fields = {tone_cfg, cmd_cfg, out_cfg};

  a_r7_cleared_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (fields == '0));

  a_r7_silent_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !sda_oe);

  a_r1_ack_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_hit |=> sda_oe);

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !wr_commit) |=> $stable(fields));

  a_r3_reserved_code_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && wr_commit && (wr_byte[7:5] == 3'b000 || wr_byte[7])) |=> $stable(fields));

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  a_r6_release_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !sda_oe);

  a_r9_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

endmodule

bind lnb_ctl_i2c_slave lnb_ctl_i2c_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_ok      (pwr_ok),
  .sda_oe      (sda_oe),
  .tone_cfg    (tone_cfg),
  .cmd_cfg     (cmd_cfg),
  .out_cfg     (out_cfg),
  .ev_addr_hit (ev_addr_hit),
  .ev_stop     (ev_stop),
  .wr_commit   (wr_commit),
  .rd_done     (rd_done),
  .wr_byte     (wr_byte),
  .wr_sel      (wr_sel)
);

// File: tb/lnb_ctl_i2c_slave_test.sv
module lnb_ctl_i2c_slave_test;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [1:0] strap = 2'b10;
  logic [4:0] status = 5'h15;
  logic [4:0] tone_cfg, cmd_cfg, out_cfg;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   chk_en = 1'b0;
  bit   done = 1'b0;
  logic [4:0] mdl [1:3];

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  lnb_ctl_i2c_slave uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .strap    (strap),
    .status_i (status),
    .tone_cfg (tone_cfg),
    .cmd_cfg  (cmd_cfg),
    .out_cfg  (out_cfg)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Reference comparison of the configuration outputs on every clock.
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk("R2/R3/R7 tone_cfg", tone_cfg, mdl[1]);
      chk("R2/R3/R7 cmd_cfg",  cmd_cfg,  mdl[2]);
      chk("R2/R3/R7 out_cfg",  out_cfg,  mdl[3]);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired");
    summary();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int idx);
    logic [4:0] pl;
    pl = (idx == 0) ? status : mdl[idx];
    return {idx[2:0], pl};
  endfunction

  function automatic void model_write(input logic [7:0] b);
    int code;
    code = int'(b[7:5]);
    if (code >= 1 && code <= 3) mdl[code] = b[4:0];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    put_bit(!master_ack);
  endtask

  task automatic addr(input logic [6:0] a, input logic rw, input bit exp_ack, input string req);
    bit ack;
    send_byte({a, rw}, ack);
    chk(req, ack, exp_ack);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack;
    chk_en = 1'b0;
    send_byte(b, ack);
    chk(req, ack, exp_ack);
    if (ack && pwr_ok) model_write(b);
    tick(2);
    chk_en = 1'b1;
  endtask

  task automatic rd_expect(input bit master_ack, input int idx, input string req);
    logic [7:0] exp, got;
    exp = exp_rd(idx);
    recv_byte(master_ack, got);
    chk(req, got, exp);
  endtask

  initial begin
    logic [7:0] junk;
    bit ack;
    mdl[1] = '0; mdl[2] = '0; mdl[3] = '0;
    tick(5);
    // R8: reset state
    chk("R8 tone_cfg reset", tone_cfg, 0);
    chk("R8 cmd_cfg reset",  cmd_cfg,  0);
    chk("R8 out_cfg reset",  out_cfg,  0);
    chk("R8 sda_oe reset",   sda_oe,   0);
    rst_n = 1'b1;
    tick(5);
    chk_en = 1'b1;

    // R1 R2 R10: matching address, several data bytes in one transaction
    bus_start();
    addr(7'h0A, 1'b0, 1'b1, "R1 address ack");
    wr_byte(8'b001_10101, 1'b1, "R2 tone write ack");
    wr_byte(8'b010_01110, 1'b1, "R10 cmd write ack");
    wr_byte(8'b011_11011, 1'b1, "R10 out write ack");
    bus_stop();

    // R3: status and reserved codes leave fields unchanged
    bus_start();
    addr(7'h0A, 1'b0, 1'b1, "R3 address ack");
    wr_byte(8'b000_11111, 1'b1, "R3 status code ack");
    wr_byte(8'b100_00001, 1'b1, "R3 code 100 ack");
    wr_byte(8'b111_10000, 1'b1, "R3 code 111 ack");
    bus_stop();

    // R1: wrong address, following byte ignored
    bus_start();
    addr(7'h08, 1'b0, 1'b0, "R1 mismatch no ack");
    wr_byte(8'b001_11111, 1'b0, "R1 byte after mismatch");
    bus_stop();

    // R4 R5: full rotation with wrap
    bus_start();
    addr(7'h0A, 1'b1, 1'b1, "R4 read address ack");
    rd_expect(1'b1, 0, "R4 status byte");
    rd_expect(1'b1, 1, "R5 second byte");
    rd_expect(1'b1, 2, "R5 third byte");
    rd_expect(1'b1, 3, "R5 fourth byte");
    rd_expect(1'b0, 0, "R5 wrap to status");
    // R6: after NACK the slave stays released
    recv_byte(1'b0, junk);
    chk("R6 released after nack", junk, 8'hFF);
    bus_stop();

    // R5: new read restarts at status; R4 live status
    status = 5'h0A;
    bus_start();
    addr(7'h0A, 1'b1, 1'b1, "R5 read address ack");
    rd_expect(1'b1, 0, "R5 restart at status");
    rd_expect(1'b0, 1, "R5 second after restart");
    bus_stop();

    // R9: bytes after STOP are ignored
    send_byte(8'b001_00000, ack);
    chk("R9 no ack after stop", ack, 0);
    // R9: repeated START mid-write
    bus_start();
    addr(7'h0A, 1'b0, 1'b1, "R9 write address ack");
    wr_byte(8'b001_00011, 1'b1, "R9 write before restart");
    bus_start();
    addr(7'h0A, 1'b1, 1'b1, "R9 repeated start ack");
    rd_expect(1'b0, 0, "R9 read after repeated start");
    bus_stop();

    // R1: other strap value
    strap = 2'b01;
    bus_start();
    addr(7'h0A, 1'b0, 1'b0, "R1 old address rejected");
    bus_stop();
    bus_start();
    addr(7'h09, 1'b0, 1'b1, "R1 strap 01 ack");
    wr_byte(8'b011_00110, 1'b1, "R1 strap 01 write");
    bus_stop();

    // R7: power-good low
    chk_en = 1'b0;
    pwr_ok = 1'b0;
    tick(3);
    mdl[1] = '0; mdl[2] = '0; mdl[3] = '0;
    chk_en = 1'b1;
    bus_start();
    addr(7'h09, 1'b0, 1'b0, "R7 no ack unpowered");
    wr_byte(8'b001_11111, 1'b0, "R7 write ignored unpowered");
    bus_stop();
    pwr_ok = 1'b1;
    tick(10);
    chk("R7 tone stays zero", tone_cfg, 0);
    bus_start();
    addr(7'h09, 1'b0, 1'b1, "R7 ack after power return");
    wr_byte(8'b010_10101, 1'b1, "R7 write after power return");
    bus_stop();
    bus_start();
    addr(7'h09, 1'b1, 1'b1, "R7 read address ack");
    rd_expect(1'b1, 0, "R7 status readback");
    rd_expect(1'b1, 1, "R7 tone readback");
    rd_expect(1'b0, 2, "R7 cmd readback");
    bus_stop();

    tick(10);
    summary();
  end

endmodule